// File: doc/BRIEF.md
# Pipelined CORDIC Quadrature Oscillator

This block is a numerically controlled oscillator that produces a pair of quadrature samples, sine and cosine, every clock cycle without any waveform table. A phase accumulator steps by an unsigned frequency word on each clock. An unsigned phase offset word is added to the accumulated value to give the current phase, where 2^PH_W stands for one full turn. The output frequency is therefore the frequency word times the clock rate divided by 2^PH_W, and the frequency step is the clock rate divided by 2^PH_W.

The two top phase bits name the quadrant. The remaining bits, zero-extended, form an angle below 90 degrees. That angle drives a chain of unrolled circular rotation stages. Each stage has its own adders and its own arctangent constant, and the rotation starts from a vector prescaled by the rotation gain, so no multiplier is needed. The quadrant code travels alongside the data through the chain. At the end, the first-quadrant pair is mapped back to the right quadrant by symmetry. The internal values carry guard bits below the output resolution, and these are removed by rounding with saturation.

Top module: `cordic_nco`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, drives `valid_out` low and drives both sample outputs to zero.
- R2: After reset is released, `valid_out` is low for the first 9 rising edges and goes high at the 10th (fold register, 8 rotation stages, output register). It then stays high until the next reset.
- R3: The sample shown after rising edge 10+n (n counted from 0) belongs to the phase (n*freq_word + phase_offset) mod 2^24. Both words are unsigned, and 2^24 is one full turn.
- R4: `sin_out` and `cos_out` are signed two's-complement 8-bit values with 1.0 mapped to 128. Each lies within 3 LSB of round(128*sin) and round(128*cos) of its phase, clamped to [-128, 127].
- R5: Phase bits [23:22] select the quadrant (00 = 0..90 degrees, 01 = 90..180, 10 = 180..270, 11 = 270..360). The sign and the swap of sine and cosine are correct in all four quadrants.
- R6: Results at or above +1.0 saturate to 127 and never wrap. At phase 0 `cos_out` is exactly 127, and at phase 2^22 `sin_out` is exactly 127.
- R7: The accumulator wraps modulo 2^24 with no break in the sequence, including for frequency words above half a turn.

Ports
## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 24 | Unsigned phase step added each clock |
| phase_offset | input | 24 | Unsigned phase added to the accumulator |
| sin_out | output | 8 | Signed sine sample |
| cos_out | output | 8 | Signed cosine sample |
| valid_out | output | 1 | High while the samples are valid |

## Verification
The bench builds the block with its default parameters: a 24-bit phase, 8-bit samples, 6 guard bits and 8 rotation stages. This gives a fixed 10-cycle latency, so every sample can be matched to its exact phase. A zero frequency word holds the phase still, which exposes the four quadrant mappings and the two points where +1.0 must saturate. Two stepping frequency words, one small and one above half a turn, check the accumulation and its modulo wrap against an independently computed sine and cosine.

// File: rtl/nco_pkg.sv
package nco_pkg;

    typedef enum logic [1:0] {
        QUAD_I   = 2'b00,
        QUAD_II  = 2'b01,
        QUAD_III = 2'b10,
        QUAD_IV  = 2'b11
    } quad_e;

    // Number of arctangent steps the constant function can supply.
    localparam int unsigned ATAN_STEPS_MAX = 12;

    // arctan(2^-idx) in units where a full turn is 2^ph_w.
    function automatic longint atan_step(input int unsigned idx, input int unsigned ph_w);
        longint base;
        case (idx)
            0:       base = 64'sd2097152;
            1:       base = 64'sd1238021;
            2:       base = 64'sd654136;
            3:       base = 64'sd332050;
            4:       base = 64'sd166669;
            5:       base = 64'sd83416;
            6:       base = 64'sd41719;
            7:       base = 64'sd20860;
            8:       base = 64'sd10430;
            9:       base = 64'sd5215;
            10:      base = 64'sd2608;
            11:      base = 64'sd1304;
            default: base = 64'sd0;
        endcase
        if (ph_w >= 24)
            return base <<< (ph_w - 24);
        else
            return base >>> (24 - ph_w);
    endfunction

    // Rotation gain compensation (about 0.607253) with frac_bits fraction bits.
    function automatic longint gain_const(input int unsigned frac_bits);
        return (64'sd607253 * (64'sd1 <<< frac_bits) + 64'sd500000) / 64'sd1000000;
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PH_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] freq_word,
    input  logic [PH_W-1:0] phase_offset,
    output logic [PH_W-1:0] phase
);
    logic [PH_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= acc_q + freq_word;
    end

    assign phase = acc_q + phase_offset;
endmodule

// File: rtl/nco_fold.sv
module nco_fold
    import nco_pkg::*;
#(
    parameter int PH_W = 24,
    parameter int Z_W  = PH_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PH_W-1:0]       phase,
    output logic signed [Z_W-1:0] z_o,
    output quad_e                 quad_o,
    output logic                  vld_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            z_o    <= '0;
            quad_o <= QUAD_I;
            vld_o  <= 1'b0;
        end else begin
            z_o    <= Z_W'({3'b000, phase[PH_W-3:0]});
            quad_o <= quad_e'(phase[PH_W-1 -: 2]);
            vld_o  <= 1'b1;
        end
    end
endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage
    import nco_pkg::*;
#(
    parameter int XY_W = 15,
    parameter int PH_W = 24,
    parameter int Z_W  = PH_W + 1,
    parameter int IDX  = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [XY_W-1:0] x_i,
    input  logic signed [XY_W-1:0] y_i,
    input  logic signed [Z_W-1:0]  z_i,
    input  quad_e                  quad_i,
    input  logic                   vld_i,
    output logic signed [XY_W-1:0] x_o,
    output logic signed [XY_W-1:0] y_o,
    output logic signed [Z_W-1:0]  z_o,
    output quad_e                  quad_o,
    output logic                   vld_o
);
    localparam logic signed [Z_W-1:0] ANG = Z_W'(atan_step(IDX, PH_W));

    logic                   ccw;
    logic signed [XY_W-1:0] x_sh, y_sh;

    assign ccw  = ~z_i[Z_W-1];
    assign x_sh = x_i >>> IDX;
    assign y_sh = y_i >>> IDX;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_o    <= '0;
            y_o    <= '0;
            z_o    <= '0;
            quad_o <= QUAD_I;
            vld_o  <= 1'b0;
        end else begin
            if (ccw) begin
                x_o <= x_i - y_sh;
                y_o <= y_i + x_sh;
                z_o <= z_i - ANG;
            end else begin
                x_o <= x_i + y_sh;
                y_o <= y_i - x_sh;
                z_o <= z_i + ANG;
            end
            quad_o <= quad_i;
            vld_o  <= vld_i;
        end
    end
endmodule

// File: rtl/nco_restore.sv
module nco_restore
    import nco_pkg::*;
#(
    parameter int XY_W  = 15,
    parameter int OUT_W = 8,
    parameter int GUARD = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [XY_W-1:0]  x_i,
    input  logic signed [XY_W-1:0]  y_i,
    input  quad_e                   quad_i,
    input  logic                    vld_i,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic                    vld_o
);
    localparam int RW = XY_W - GUARD;
    localparam logic signed [XY_W:0] HALF = (XY_W+1)'(1 << (GUARD - 1));
    localparam logic signed [RW:0]   Q_HI = (RW+1)'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [RW:0]   Q_LO = ~Q_HI;

    function automatic logic signed [OUT_W-1:0] round_sat(input logic signed [XY_W-1:0] v);
        logic signed [XY_W:0] t;
        logic signed [RW:0]   q;
        t = {v[XY_W-1], v} + HALF;
        q = (RW+1)'(t >>> GUARD);
        if (q > Q_HI)
            return Q_HI[OUT_W-1:0];
        else if (q < Q_LO)
            return Q_LO[OUT_W-1:0];
        else
            return q[OUT_W-1:0];
    endfunction

    logic signed [XY_W-1:0] s_sel, c_sel;

    always_comb begin
        unique case (quad_i)
            QUAD_I:   begin s_sel = y_i;  c_sel = x_i;  end
            QUAD_II:  begin s_sel = x_i;  c_sel = -y_i; end
            QUAD_III: begin s_sel = -y_i; c_sel = -x_i; end
            default:  begin s_sel = -x_i; c_sel = y_i;  end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_o <= '0;
            cos_o <= '0;
            vld_o <= 1'b0;
        end else begin
            sin_o <= round_sat(s_sel);
            cos_o <= round_sat(c_sel);
            vld_o <= vld_i;
        end
    end
endmodule

// File: rtl/cordic_nco.sv
module cordic_nco
    import nco_pkg::*;
#(
    parameter int PH_W   = 24,
    parameter int OUT_W  = 8,
    parameter int GUARD  = 6,
    parameter int STAGES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PH_W-1:0]         freq_word,
    input  logic [PH_W-1:0]         phase_offset,
    output logic signed [OUT_W-1:0] sin_out,
    output logic signed [OUT_W-1:0] cos_out,
    output logic                    valid_out
);
    // One headroom bit above 1.0 plus GUARD bits below the output LSB.
    localparam int XY_W     = OUT_W + GUARD + 1;
    localparam int Z_W      = PH_W + 1;
    localparam int FRAC     = OUT_W - 1 + GUARD;
    localparam logic signed [XY_W-1:0] X_INIT = XY_W'(gain_const(FRAC));

    logic [PH_W-1:0]        phase;
    logic signed [XY_W-1:0] x_p [0:STAGES];
    logic signed [XY_W-1:0] y_p [0:STAGES];
    logic signed [Z_W-1:0]  z_p [0:STAGES];
    quad_e                  q_p [0:STAGES];
    logic                   v_p [0:STAGES];

    nco_phase_acc #(.PH_W(PH_W)) u_acc (
        .clk          (clk),
        .rst          (rst),
        .freq_word    (freq_word),
        .phase_offset (phase_offset),
        .phase        (phase)
    );

    nco_fold #(.PH_W(PH_W), .Z_W(Z_W)) u_fold (
        .clk    (clk),
        .rst    (rst),
        .phase  (phase),
        .z_o    (z_p[0]),
        .quad_o (q_p[0]),
        .vld_o  (v_p[0])
    );

    assign x_p[0] = X_INIT;
    assign y_p[0] = '0;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        nco_cordic_stage #(
            .XY_W (XY_W),
            .PH_W (PH_W),
            .Z_W  (Z_W),
            .IDX  (s)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .x_i    (x_p[s]),
            .y_i    (y_p[s]),
            .z_i    (z_p[s]),
            .quad_i (q_p[s]),
            .vld_i  (v_p[s]),
            .x_o    (x_p[s+1]),
            .y_o    (y_p[s+1]),
            .z_o    (z_p[s+1]),
            .quad_o (q_p[s+1]),
            .vld_o  (v_p[s+1])
        );
    end

    nco_restore #(.XY_W(XY_W), .OUT_W(OUT_W), .GUARD(GUARD)) u_out (
        .clk    (clk),
        .rst    (rst),
        .x_i    (x_p[STAGES]),
        .y_i    (y_p[STAGES]),
        .quad_i (q_p[STAGES]),
        .vld_i  (v_p[STAGES]),
        .sin_o  (sin_out),
        .cos_o  (cos_out),
        .vld_o  (valid_out)
    );
endmodule

// File: rtl/cordic_nco_chk.sv
module cordic_nco_chk #(
    parameter int OUT_W  = 8,
    parameter int STAGES = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic signed [OUT_W-1:0] sin_out,
    input logic signed [OUT_W-1:0] cos_out,
    input logic                    valid_out
);
    localparam int LAT = STAGES + 2;
    localparam int FS2 = (1 << (OUT_W - 1)) * (1 << (OUT_W - 1));

    int run_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= 0;
        else if (run_cnt < LAT + 1)
            run_cnt <= run_cnt + 1;
    end

    int mag2;
    assign mag2 = int'(sin_out) * int'(sin_out) + int'(cos_out) * int'(cos_out);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == 0) |-> (!valid_out && sin_out == 0 && cos_out == 0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        valid_out == (run_cnt >= LAT));

    // R2
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> valid_out);

    // R4
    magnitude_chk: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> (mag2 >= FS2 - FS2 / 16 && mag2 <= FS2 + FS2 / 16));
endmodule

bind cordic_nco cordic_nco_chk #(.OUT_W(OUT_W), .STAGES(STAGES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sin_out   (sin_out),
    .cos_out   (cos_out),
    .valid_out (valid_out)
);

// File: tb/cordic_nco_test.sv
module cordic_nco_test;
    localparam int PH_W = 24;
    localparam int LAT  = 10;
    localparam int TOL  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PH_W-1:0]   freq_word = '0;
    logic [PH_W-1:0]   phase_offset = '0;
    logic signed [7:0] sin_out, cos_out;
    logic              valid_out;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    cordic_nco uut (
        .clk          (clk),
        .rst          (rst),
        .freq_word    (freq_word),
        .phase_offset (phase_offset),
        .sin_out      (sin_out),
        .cos_out      (cos_out),
        .valid_out    (valid_out)
    );

    function automatic int ideal(input longint ph, input bit want_sin);
        real ang, v;
        int  r;
        ang = 2.0 * 3.141592653589793 * real'(ph) / 16777216.0;
        v   = want_sin ? 128.0 * $sin(ang) : 128.0 * $cos(ang);
        r   = $rtoi($floor(v + 0.5));
        if (r > 127)  r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp, input int tol);
        int d;
        n_checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
        end
    endtask

    task automatic start(input logic [PH_W-1:0] fw, input logic [PH_W-1:0] po);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        freq_word    = fw;
        phase_offset = po;
        rst          = 1'b0;
    endtask

    // R1 and R2: reset state and fixed latency.
    task automatic t_reset_latency();
        start(24'h000100, 24'h0);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", int'(valid_out), 0, 0);
        check("R1", "sin in reset", int'(sin_out), 0, 0);
        check("R1", "cos in reset", int'(cos_out), 0, 0);
        rst = 1'b0;
        for (int k = 1; k <= LAT + 3; k++) begin
            @(negedge clk);
            if (k == LAT - 1) check("R2", "valid at edge 9", int'(valid_out), 0, 0);
            if (k == LAT)     check("R2", "valid at edge 10", int'(valid_out), 1, 0);
            if (k == LAT + 3) check("R2", "valid held", int'(valid_out), 1, 0);
        end
    endtask

    // R5: fixed phase in each quadrant.
    task automatic t_quadrant(input logic [PH_W-1:0] po, input string tag);
        start(24'h0, po);
        repeat (LAT + 2) @(negedge clk);
        check("R5", {tag, " sin"}, int'(sin_out), ideal(longint'(po), 1'b1), TOL);
        check("R5", {tag, " cos"}, int'(cos_out), ideal(longint'(po), 1'b0), TOL);
    endtask

    // R6: full-scale points saturate to 127 exactly.
    task automatic t_saturate();
        start(24'h0, 24'h000000);
        repeat (LAT + 1) @(negedge clk);
        check("R6", "cos at phase 0", int'(cos_out), 127, 0);
        check("R6", "sin at phase 0", int'(sin_out), 0, TOL);
        start(24'h0, 24'h400000);
        repeat (LAT + 1) @(negedge clk);
        check("R6", "sin at quarter turn", int'(sin_out), 127, 0);
        check("R6", "cos at quarter turn", int'(cos_out), 0, TOL);
        start(24'h0, 24'h800000);
        repeat (LAT + 1) @(negedge clk);
        check("R6", "cos at half turn", int'(cos_out), -128, TOL);
    endtask

    // R3, R4, R7: stepping phase compared sample by sample.
    task automatic t_sweep(input logic [PH_W-1:0] fw, input logic [PH_W-1:0] po,
                           input int n, input string req);
        longint ph;
        start(fw, po);
        repeat (LAT - 1) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ph = (longint'(k) * longint'(fw) + longint'(po)) % 64'sd16777216;
            check(req, $sformatf("sin sample %0d", k), int'(sin_out), ideal(ph, 1'b1), TOL);
            check(req, $sformatf("cos sample %0d", k), int'(cos_out), ideal(ph, 1'b0), TOL);
        end
    endtask

    initial begin
        t_reset_latency();
        t_quadrant(24'd1398101,  "R5 q1 30deg");
        t_quadrant(24'd5592405,  "R5 q2 120deg");
        t_quadrant(24'd9786709,  "R5 q3 210deg");
        t_quadrant(24'd13981013, "R5 q4 300deg");
        t_saturate();
        t_sweep(24'h012345, 24'h0A0000, 60, "R3/R4");
        t_sweep(24'hE38E39, 24'h000000, 40, "R7");
        t_sweep(24'h2AAAAB, 24'hF00000, 30, "R7 offset");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule